// File: doc/BRIEF.md
# Output-Compare PWM Channel

This block is one compare channel of a general-purpose timer. It watches a count value supplied by a shared timebase and compares it with its own compare register. Depending on a 3-bit mode it drives a reference level that holds, changes on a match, is forced, or forms a pulse-width-modulated waveform. That reference passes through a polarity inverter and an output enable before it reaches the pin. A sticky flag records each match event until software clears it.

The compare register can be written directly, or it can be shadowed so that a new value waits for the timebase's update event. Shadowing lets software change the duty cycle mid-period without producing a glitched pulse. Several channels normally share one counter, each with its own compare value and mode.

Top module: `oc_pwm_channel`

## Requirements
- R1: While `rst_n` is low, the active compare value, the reference and the match flag are 0, so `pin_o` equals `pol_i` and `match_flag_o` is 0.
- R2: Mode encodings 0, 4 and 5 act on the reference as follows. Mode 0 holds it. Mode 4 drives it to 0. Mode 5 drives it to 1. Each reference update shows on `pin_o` one clock after the count value it was computed from.
- R3: Mode 1 sets the reference to 1 on a match event. Mode 2 clears it to 0 on a match event. Without a match event the reference holds in both modes.
- R4: Mode 3 inverts the reference once per match event. A match event is the first cycle in which the count equals the active compare value after a cycle in which it did not.
- R5: Mode 6 behaves as follows. When `cnt_dn_i` is 0, the reference is 1 while the count is below the compare value. When `cnt_dn_i` is 1, the reference is 1 while the count is at or below the compare value. With up-counting, a compare value of 0 gives 0 % duty and a value above the reload gives 100 % duty.
- R6: Mode 7 produces the inverse of the mode 6 reference.
- R7: With `preload_en_i` at 0, a value written with `cmp_wr_i` becomes the active compare value on the next clock.
- R8: With `preload_en_i` at 1, a write goes only to the shadow register. The active compare value changes only on a clock where `upd_evt_i` is 1. A write in that same cycle is taken directly.
- R9: With `pol_i` at 1, the reference is inverted on its way to the pin.
- R10: With `out_en_i` at 0, `pin_o` holds the inactive level, which equals `pol_i`, whatever the reference does.
- R11: `match_flag_o` sets on the clock after a match event and stays set until `flag_clr_i` is pulsed. Setting wins over a clear in the same cycle. A counter halted on the compare value causes no further events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Shared timebase count |
| cnt_dn_i | input | 1 | Count direction, 1 = down |
| upd_evt_i | input | 1 | Timebase update event (reload/wrap) |
| cmp_wr_i | input | 1 | Compare register write strobe |
| cmp_wdata_i | input | CNT_W | Compare write data |
| mode_i | input | 3 | Channel mode encoding |
| preload_en_i | input | 1 | Shadow the compare register |
| pol_i | input | 1 | Output polarity, 1 = inverted |
| out_en_i | input | 1 | Output enable |
| flag_clr_i | input | 1 | Clear the match flag |
| pin_o | output | 1 | Channel output level |
| match_flag_o | output | 1 | Sticky compare-match flag |

## Verification
The bench builds four channels at the default 16-bit width and shares one counter that wraps every ten clocks, with a reload of 9. The short period puts whole PWM periods, update events and wrap-around inside a few dozen cycles. It also makes a compare value above the reload easy to reach, which is how 100 % duty is produced. The counter can be reversed and halted, which exposes the down-count PWM rule and the behaviour of a counter parked on the compare value.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_FROZEN   = 3'd0,
    OC_SET_HIT  = 3'd1,
    OC_CLR_HIT  = 3'd2,
    OC_TOG_HIT  = 3'd3,
    OC_FORCE_LO = 3'd4,
    OC_FORCE_HI = 3'd5,
    OC_PWM_A    = 3'd6,
    OC_PWM_B    = 3'd7
  } oc_mode_e;
endpackage

// File: rtl/oc_cmp_reg.sv
module oc_cmp_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             preload_i,
  input  logic             upd_i,
  output logic [CNT_W-1:0] cmp_o
);
  logic [CNT_W-1:0] shadow_q, shadow_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             act_en;

  always_comb begin
    shadow_d = wr_i ? wdata_i : shadow_q;
    act_en   = preload_i ? upd_i : wr_i;
    act_d    = wr_i ? wdata_i : shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= shadow_d;
      if (act_en) act_q <= act_d;
    end
  end

  assign cmp_o = act_q;

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_i && !upd_i) |=> $stable(act_q)); // R8
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_i && wr_i) |=> (act_q == $past(wdata_i))); // R7
endmodule

// File: rtl/oc_match_det.sv
module oc_match_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clr_i,
  output logic             evt_o,
  output logic             flag_o
);
  logic eq, eq_prev_q;
  logic flag_q, flag_d;

  always_comb begin
    eq     = (cnt_i == cmp_i);
    evt_o  = eq && !eq_prev_q;
    flag_d = evt_o ? 1'b1 : (clr_i ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_prev_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      eq_prev_q <= eq;
      flag_q    <= flag_d;
    end
  end

  assign flag_o = flag_q;

  AST_FLAG_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> flag_q); // R11
  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o); // R11
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             dn_i,
  input  logic             evt_i,
  output logic             ref_o
);
  oc_mode_e mode;
  logic     ref_q, ref_d, ref_en, pwm_on;

  always_comb begin
    mode   = oc_mode_e'(mode_i);
    pwm_on = dn_i ? (cnt_i <= cmp_i) : (cnt_i < cmp_i);
    ref_en = 1'b1;
    ref_d  = ref_q;
    case (mode)
      OC_FROZEN:   ref_en = 1'b0;
      OC_SET_HIT:  begin ref_en = evt_i; ref_d = 1'b1;   end
      OC_CLR_HIT:  begin ref_en = evt_i; ref_d = 1'b0;   end
      OC_TOG_HIT:  begin ref_en = evt_i; ref_d = !ref_q; end
      OC_FORCE_LO: ref_d = 1'b0;
      OC_FORCE_HI: ref_d = 1'b1;
      OC_PWM_A:    ref_d = pwm_on;
      OC_PWM_B:    ref_d = !pwm_on;
      default:     ref_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= 1'b0;
    else if (ref_en) ref_q <= ref_d;
  end

  assign ref_o = ref_q;

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd5) |=> ref_q); // R2
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd4) |=> !ref_q); // R2
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd0) |=> $stable(ref_q)); // R2
  AST_TOGGLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd3 && evt_i) |=> (ref_q != $past(ref_q))); // R4
  AST_TOGGLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd3 && !evt_i) |=> $stable(ref_q)); // R4
endmodule

// File: rtl/oc_pwm_channel.sv
module oc_pwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_dn_i,
  input  logic             upd_evt_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic [2:0]       mode_i,
  input  logic             preload_en_i,
  input  logic             pol_i,
  input  logic             out_en_i,
  input  logic             flag_clr_i,
  output logic             pin_o,
  output logic             match_flag_o
);
  logic [CNT_W-1:0] cmp_act;
  logic             hit_evt;
  logic             oc_ref;

  oc_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_i(cmp_wr_i), .wdata_i(cmp_wdata_i),
    .preload_i(preload_en_i), .upd_i(upd_evt_i), .cmp_o(cmp_act)
  );

  oc_match_det #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cmp_i(cmp_act),
    .clr_i(flag_clr_i), .evt_o(hit_evt), .flag_o(match_flag_o)
  );

  oc_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cnt_i(cnt_i),
    .cmp_i(cmp_act), .dn_i(cnt_dn_i), .evt_i(hit_evt), .ref_o(oc_ref)
  );

  always_comb begin
    pin_o = out_en_i ? (oc_ref ^ pol_i) : pol_i;
  end
endmodule

// File: tb/oc_pwm_channel_test.sv
module oc_pwm_channel_test;
  localparam int W = 16;
  localparam int N = 4;
  localparam logic [W-1:0] RELOAD = 16'd9;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [W-1:0] cnt;
  logic cnt_dn, run, upd;
  assign upd = run && (cnt_dn ? (cnt == '0) : (cnt == RELOAD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (run) begin
      if (cnt_dn) cnt <= (cnt == '0) ? RELOAD : cnt - 1'b1;
      else        cnt <= (cnt == RELOAD) ? '0 : cnt + 1'b1;
    end
  end

  logic [2:0]   md  [N];
  logic         wr  [N];
  logic [W-1:0] wd  [N];
  logic         pre [N];
  logic         pol [N];
  logic         en  [N];
  logic         clr [N];
  logic         pin [N];
  logic         flg [N];

  for (genvar g = 0; g < N; g++) begin : gen_ch
    oc_pwm_channel #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_dn_i(cnt_dn),
      .upd_evt_i(upd), .cmp_wr_i(wr[g]), .cmp_wdata_i(wd[g]),
      .mode_i(md[g]), .preload_en_i(pre[g]), .pol_i(pol[g]),
      .out_en_i(en[g]), .flag_clr_i(clr[g]), .pin_o(pin[g]),
      .match_flag_o(flg[g])
    );
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model and scoreboard
  typedef struct packed {
    logic [N-1:0] r;
    logic [N-1:0] f;
    logic [N*3-1:0] m;
  } exp_t;
  exp_t q[$];
  logic [W-1:0] m_cmp[N], m_sh[N];
  logic m_eqp[N], m_ref[N], m_flg[N];

  always @(posedge clk) begin
    exp_t e;
    logic eq, ev, nr, pw;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_cmp[i] = '0; m_sh[i] = '0; m_eqp[i] = 0; m_ref[i] = 0; m_flg[i] = 0;
      end
      q.delete();
    end else begin
      for (int i = 0; i < N; i++) begin
        eq = (cnt == m_cmp[i]);
        ev = eq && !m_eqp[i];
        pw = cnt_dn ? (cnt <= m_cmp[i]) : (cnt < m_cmp[i]);
        case (md[i])
          3'd0: nr = m_ref[i];
          3'd1: nr = ev ? 1'b1 : m_ref[i];
          3'd2: nr = ev ? 1'b0 : m_ref[i];
          3'd3: nr = ev ? !m_ref[i] : m_ref[i];
          3'd4: nr = 1'b0;
          3'd5: nr = 1'b1;
          3'd6: nr = pw;
          default: nr = !pw;
        endcase
        m_flg[i] = ev ? 1'b1 : (clr[i] ? 1'b0 : m_flg[i]);
        if (pre[i]) begin
          if (upd) m_cmp[i] = wr[i] ? wd[i] : m_sh[i];
        end else if (wr[i]) m_cmp[i] = wd[i];
        if (wr[i]) m_sh[i] = wd[i];
        m_eqp[i] = eq;
        m_ref[i] = nr;
        e.r[i] = nr;
        e.f[i] = m_flg[i];
        e.m[i*3 +: 3] = md[i];
      end
      q.push_back(e);
    end
  end

  function automatic string tag_of(logic [2:0] m);
    case (m)
      3'd1, 3'd2: return "R3";
      3'd3:       return "R4";
      3'd6:       return "R5";
      3'd7:       return "R6";
      default:    return "R2";
    endcase
  endfunction

  always begin
    exp_t e;
    logic xp;
    @(negedge clk); #1;
    if (rst_n && q.size() > 0) begin
      e = q.pop_front();
      for (int i = 0; i < N; i++) begin
        xp = en[i] ? (e.r[i] ^ pol[i]) : pol[i];
        chk(en[i] ? (pol[i] ? "R9 pin" : tag_of(e.m[i*3 +: 3])) : "R10 pin",
            int'(pin[i]), int'(xp));
        chk("R11 flag", int'(flg[i]), int'(e.f[i]));
      end
    end
  end

  task automatic wr_cmp(int ch, logic [W-1:0] v);
    @(negedge clk); wr[ch] = 1'b1; wd[ch] = v;
    @(negedge clk); wr[ch] = 1'b0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic duty(int ch, int exp, string tag);
    int h = 0;
    repeat (10) begin @(negedge clk); #1; h += int'(pin[ch]); end
    chk(tag, h, exp);
  endtask

  task automatic wait_cnt(logic [W-1:0] v);
    do @(negedge clk); while (cnt != v);
  endtask

  initial begin
    int tg;
    logic prev;
    for (int i = 0; i < N; i++) begin
      md[i] = 3'd0; wr[i] = 0; wd[i] = '0; pre[i] = 0;
      pol[i] = (i == 1); en[i] = 1; clr[i] = 0;
    end
    run = 0; cnt_dn = 0; rst_n = 0;
    cyc(3); #1;
    for (int i = 0; i < N; i++) begin
      chk("R1 pin", int'(pin[i]), int'(pol[i]));
      chk("R1 flag", int'(flg[i]), 0);
    end
    @(negedge clk);
    pol[1] = 0; rst_n = 1; run = 1;
    md[0] = 3'd6; md[1] = 3'd7; md[2] = 3'd3; md[3] = 3'd1;
    wr_cmp(0, 4); wr_cmp(1, 4); wr_cmp(2, 3); wr_cmp(3, 7);
    cyc(30);
    duty(0, 4, "R5 up cmp4");
    duty(1, 6, "R6 cmp4");
    wr_cmp(0, 0);  cyc(12); duty(0, 0,  "R5 zero duty");
    wr_cmp(0, 20); cyc(12); duty(0, 10, "R5 full duty");
    wr_cmp(0, 4);  cyc(12);
    @(negedge clk); pol[0] = 1; cyc(2); duty(0, 6, "R9 inverted");
    @(negedge clk); pol[0] = 0; en[0] = 0; duty(0, 0, "R10 disabled");
    @(negedge clk); pol[0] = 1; duty(0, 10, "R10 disabled inv");
    @(negedge clk); pol[0] = 0; en[0] = 1; cyc(12);
    // R7: direct write takes effect next clock
    wait_cnt(5); wr[0] = 1'b1; wd[0] = 16'd8;
    @(negedge clk); wr[0] = 1'b0;
    @(negedge clk); #1; chk("R7 immediate", int'(pin[0]), 1);
    wr_cmp(0, 4); cyc(12);
    // R8: shadowed write waits for update
    @(negedge clk); pre[0] = 1'b1;
    wait_cnt(5); wr[0] = 1'b1; wd[0] = 16'd8;
    @(negedge clk); wr[0] = 1'b0; #1; chk("R8 held a", int'(pin[0]), 0);
    @(negedge clk); #1; chk("R8 held b", int'(pin[0]), 0);
    @(negedge clk); #1; chk("R8 held c", int'(pin[0]), 0);
    cyc(6); duty(0, 8, "R8 after update");
    // forced and frozen modes
    @(negedge clk); md[2] = 3'd4; md[3] = 3'd5; cyc(3); #1;
    chk("R2 force low", int'(pin[2]), 0);
    chk("R2 force high", int'(pin[3]), 1);
    @(negedge clk); md[2] = 3'd0; duty(2, 0, "R2 frozen");
    @(negedge clk); md[3] = 3'd2; cyc(12); #1;
    chk("R3 clear on match", int'(pin[3]), 0);
    @(negedge clk); md[3] = 3'd1; cyc(12); #1;
    chk("R3 set on match", int'(pin[3]), 1);
    // toggle: two transitions over twenty clocks
    @(negedge clk); md[2] = 3'd3; cyc(2);
    tg = 0; #1; prev = pin[2];
    repeat (20) begin @(negedge clk); #1; if (pin[2] != prev) tg++; prev = pin[2]; end
    chk("R4 toggle count", tg, 2);
    // down counting
    @(negedge clk); cnt_dn = 1'b1; cyc(12);
    duty(0, 9, "R5 down cmp8");
    // halted counter sitting on the compare value
    @(negedge clk); run = 1'b0; cnt_dn = 1'b0;
    wr_cmp(3, 16'd100);
    @(negedge clk); clr[3] = 1'b1; @(negedge clk); clr[3] = 1'b0;
    wr_cmp(3, cnt); cyc(3); #1;
    chk("R11 set on hit", int'(flg[3]), 1);
    @(negedge clk); clr[3] = 1'b1; @(negedge clk); clr[3] = 1'b0;
    cyc(5); #1;
    chk("R11 no re-set", int'(flg[3]), 0);
    cyc(2);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule